// File: doc/BRIEF.md
# Event-Armed Delay Pacer

This block holds back an interrupt until a programmed number of prescaler ticks has passed since the first event. While idle, the block does not count. An event arms it, and it then counts prescaler tick strobes. Once the count has reached the programmed delay, the next tick produces a single-cycle paced pulse. A delay setting of zero switches pacing off completely.

A companion divider can end the wait early through a chain-select input. A debug port shows the current stable state. The delay setting arrives directly on a port, and the block never latches it. The prescaler and the divider are outside the block.

Top module: `evt_pace_fsm`

## Requirements
- R1: After reset the block is idle: `state_o` reads 0 and `pulse_o` is low.
- R2: With `delay_cfg` equal to 0, events and ticks never raise `pulse_o`, and the block stays idle. If `delay_cfg` becomes 0 while counting, the block is idle after the next clock edge and emits no pulse.
- R3: `state_o` uses three codes: 0 for idle, 1 for counting and 2 for pulse. A clock edge with `evt_i` high and a non-zero `delay_cfg` moves an idle block to counting, with the count cleared to 0.
- R4: Ticks that arrive while the block is idle are ignored. Counting starts only when an event arrives.
- R5: While counting, each tick edge with `chain_i` low raises the count by one as long as the count is below `delay_cfg`. An edge without a tick and with `chain_i` low keeps the block counting and leaves the count unchanged.
- R6: While counting, a tick edge at which the count is at or above `delay_cfg` moves the block to the pulse state. The pulse therefore appears after the (`delay_cfg`+1)-th tick edge following the arming edge. Comparisons are unsigned on 8 bits.
- R7: `pulse_o` is high for exactly one cycle, and only while `state_o` reads 2. Without a new event, the block is idle on the following cycle.
- R8: An event present while the block is in the pulse state re-arms it directly into counting, with the count at 0.
- R9: Events that arrive while counting neither restart nor shorten the delay.
- R10: While counting, `chain_i` high moves the block to the pulse state at the next clock edge, whatever the count and tick values are.
- R11: If `delay_cfg` is lowered below the present count during counting, the next tick edge produces the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 1 | Event pulse that arms the delay |
| tick_i | input | 1 | Prescaler tick strobe |
| chain_i | input | 1 | Companion divider handover request |
| delay_cfg | input | 8 | Delay in prescaler ticks; 0 disables pacing |
| pulse_o | output | 1 | Single-cycle paced pulse |
| state_o | output | 2 | Debug state code (0 idle, 1 counting, 2 pulse) |

## Verification
Delays from 1 to 8 and also 255 are swept with ticks spaced one, two and three clocks apart, so an error in tick counting shows up differently from an error in clock counting. Each setting is run with and without ticks before the event, which tells a counter armed by the event from one that runs freely. Each setting is also run with and without extra events during the wait, which shows whether a late event restarts the delay. Directed sequences cover the zero setting, the drop to zero while counting, a re-arm in the pulse cycle, the chain handover and a setting lowered below the count. Each of these leaves its own mark on the timing of the pulse or on the state code.

// File: rtl/evt_pace_fsm.sv
module evt_pace_fsm #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt_i,
  input  logic          tick_i,
  input  logic          chain_i,
  input  logic [CW-1:0] delay_cfg,
  output logic          pulse_o,
  output logic [1:0]    state_o
);

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_DELAY = 2'd1,
    ST_OUT   = 2'd2
  } st_t;

  st_t           st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  wire armed = |delay_cfg;
  wire below = cnt_q < delay_cfg;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_WAIT:
        if (evt_i && below) begin
          st_d  = ST_DELAY;
          cnt_d = '0;
        end
      ST_DELAY:
        if (!armed) begin
          st_d  = ST_WAIT;
          cnt_d = '0;
        end else if (chain_i) begin
          st_d  = ST_OUT;
          cnt_d = '0;
        end else if (tick_i) begin
          if (below) begin
            cnt_d = cnt_q + 1'b1;
          end else begin
            st_d  = ST_OUT;
            cnt_d = '0;
          end
        end
      ST_OUT: begin
        cnt_d = '0;
        st_d  = (evt_i && armed) ? ST_DELAY : ST_WAIT;
      end
      default: begin
        st_d  = ST_WAIT;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_WAIT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign pulse_o = (st_q == ST_OUT);
  assign state_o = st_q;

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_cfg == '0) |=> (st_q == ST_WAIT));

  assert_out_from_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OUT) |-> ($past(st_q) == ST_DELAY));

  assert_arm_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DELAY && $past(st_q) != ST_DELAY) |-> (cnt_q == '0));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DELAY && armed && !tick_i && !chain_i) |=> (st_q == ST_DELAY && $stable(cnt_q)));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DELAY && armed && tick_i && !chain_i && below) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_chain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DELAY && armed && chain_i) |=> pulse_o);

endmodule

// File: tb/test_evt_pace_fsm.sv
module test_evt_pace_fsm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt = 1'b0, tick = 1'b0, chain = 1'b0;
  logic [7:0] cfg = 8'd0;
  logic       pulse;
  logic [1:0] state;
  int nchk = 0, nfail = 0, ncyc = 0;

  always #2 clk = ~clk;

  evt_pace_fsm i_evt_pace_fsm (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .tick_i(tick), .chain_i(chain),
    .delay_cfg(cfg), .pulse_o(pulse), .state_o(state)
  );

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", ncyc);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  task automatic step(input logic e, input logic t, input logic c, input logic [7:0] k);
    @(negedge clk);
    evt = e; tick = t; chain = c; cfg = k;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic exp_p, input logic [1:0] exp_s);
    nchk++;
    if (pulse !== exp_p || state !== exp_s) begin
      nfail++;
      $display("FAIL %s: actual pulse=%0b state=%0d, expected pulse=%0b state=%0d",
               tag, pulse, state, exp_p, exp_s);
    end
  endtask

  task automatic run_case(input int k, input int p, input int pre, input bit noise);
    int last;
    last = (k + 1) * p;
    for (int j = 0; j < pre; j++) begin
      step(1'b0, 1'b1, 1'b0, k[7:0]);
      chk("R4 ticks while idle", 1'b0, 2'd0);
    end
    step(1'b1, 1'b0, 1'b0, k[7:0]);
    chk("R3 arm", 1'b0, 2'd1);
    for (int i = 1; i <= last; i++) begin
      step(noise && (i % 2 == 1), (i % p) == 0, 1'b0, k[7:0]);
      if (i < last) chk("R5 R9 counting", 1'b0, 2'd1);
      else          chk("R6 pulse timing", 1'b1, 2'd2);
    end
    step(1'b0, 1'b0, 1'b0, k[7:0]);
    chk("R7 single pulse", 1'b0, 2'd0);
  endtask

  initial begin
    #1;
    chk("R1 reset", 1'b0, 2'd0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 8'd0);
    chk("R1 after reset", 1'b0, 2'd0);

    for (int i = 0; i < 24; i++) begin
      step(i % 3 != 2, i % 2 == 0, i % 5 == 0, 8'd0);
      chk("R2 disabled", 1'b0, 2'd0);
    end

    for (int k = 1; k <= 8; k++)
      for (int p = 1; p <= 3; p++)
        for (int pre = 0; pre <= 2; pre += 2)
          for (int n = 0; n <= 1; n++)
            run_case(k, p, pre, n[0]);
    run_case(255, 1, 0, 1'b0);
    run_case(255, 2, 1, 1'b1);

    step(1'b1, 1'b0, 1'b0, 8'd4);
    chk("R3 arm", 1'b0, 2'd1);
    step(1'b0, 1'b1, 1'b0, 8'd4);
    step(1'b0, 1'b1, 1'b0, 8'd4);
    chk("R5 counting", 1'b0, 2'd1);
    step(1'b0, 1'b0, 1'b0, 8'd0);
    chk("R2 drop to zero", 1'b0, 2'd0);
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 1'b1, 1'b0, 8'd4);
      chk("R2 no pulse after drop", 1'b0, 2'd0);
    end

    step(1'b1, 1'b0, 1'b0, 8'd2);
    for (int i = 1; i <= 3; i++) begin
      step(1'b0, 1'b1, 1'b0, 8'd2);
      chk("R6 first pulse before re-arm", i == 3, (i == 3) ? 2'd2 : 2'd1);
    end
    step(1'b1, 1'b0, 1'b0, 8'd2);
    chk("R8 re-arm from pulse", 1'b0, 2'd1);
    for (int i = 1; i <= 3; i++) begin
      step(1'b0, 1'b1, 1'b0, 8'd2);
      chk("R8 second delay", i == 3, (i == 3) ? 2'd2 : 2'd1);
    end
    step(1'b0, 1'b0, 1'b0, 8'd2);
    chk("R7 idle after pulse", 1'b0, 2'd0);

    step(1'b1, 1'b0, 1'b0, 8'd5);
    step(1'b0, 1'b1, 1'b0, 8'd5);
    step(1'b0, 1'b1, 1'b0, 8'd5);
    chk("R5 before chain", 1'b0, 2'd1);
    step(1'b0, 1'b0, 1'b1, 8'd5);
    chk("R10 chain handover", 1'b1, 2'd2);
    step(1'b0, 1'b0, 1'b0, 8'd5);
    chk("R10 idle after handover", 1'b0, 2'd0);

    step(1'b1, 1'b0, 1'b0, 8'd10);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 1'b0, 8'd10);
    chk("R5 count six", 1'b0, 2'd1);
    step(1'b0, 1'b0, 1'b0, 8'd3);
    chk("R11 lowered, no tick", 1'b0, 2'd1);
    step(1'b0, 1'b1, 1'b0, 8'd3);
    chk("R11 lowered below count", 1'b1, 2'd2);
    step(1'b0, 1'b0, 1'b0, 8'd3);
    chk("R7 idle", 1'b0, 2'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule